// File: doc/BRIEF.md
# Interrupt controller with pin-change wake

This block collects interrupt events for a small 8-bit core and decides when the core is interrupted or woken. There are three event sources. The first is a timer overflow pulse. The second is a change detector on a general-purpose port. The third is an external interrupt that shares one of the port pins. Each event sets a sticky flag in a status register. A mask register selects which flags may raise a request. A global enable, set and cleared by dedicated instructions, gates the request to the core.

The port-change detector compares each synchronised input pin against a reference value. That reference is captured whenever software reads the port. Pins driven as outputs are left out of the comparison. The shared pin is also left out while it serves as the external interrupt input. The external interrupt fires on a falling edge of that pin.

While the core sleeps, a pending port-change flag raises a wake request, but only if the change interrupt was enabled when the sleep instruction executed. A companion output tells the core what to do on wake. When the global enable is on, the core branches to the interrupt vector. When it is off, the core resumes at the next address.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset the status flags, the mask register and the global enable are all 0, and `irq_o` and `wake_o` are low.
- R2: A high `tmr_ovf_i` at a clock edge sets status bit 0 (timer flag) at that edge.
- R3: Status bit 1 (port-change flag) is set when some synchronised pin differs from the reference and that pin is an input (`dir_i` bit = 1). Pins with `dir_i` bit = 0 are ignored. Pin `SHARED_PIN` is also ignored while `ext_mode_i` = 1. A pin change at the ports reaches the flag `SYNC_STAGES`+1 clock edges later.
- R4: A high `port_rd_i` loads the reference with the synchronised port value, so a port that has not changed since the read raises no change flag.
- R5: Status bit 2 (external flag) is set one edge after a falling edge of synchronised pin `SHARED_PIN`, only while `ext_mode_i` = 1. A rising edge sets nothing.
- R6: `stat_wr_i` clears each status bit whose `stat_wdata_i` bit is 0 and leaves bits written 1 unchanged. An event arriving in the same cycle as a clear sets its flag.
- R7: `mask_wr_i` loads the mask from `mask_wdata_i`. `irq_o` is high exactly when the global enable is 1 and some status bit is 1 together with its mask bit.
- R8: `eni_i` sets the global enable. `disi_i` clears it, and so does `irq_ack_i` (the core taking an interrupt). A clear in the same cycle as `eni_i` wins.
- R9: While `asleep_i` = 1, `wake_o` is high when the port-change flag is set and mask bit 1 was 1 at the last `sleep_enter_i` pulse. The mask value afterwards does not matter.
- R10: `wake_vec_o` equals the global enable: 1 means branch to `vector_o` (default 0x008), 0 means continue at the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_i | input | PORT_W | Raw port pin levels |
| dir_i | input | PORT_W | Pin direction, 1 = input |
| ext_mode_i | input | 1 | Shared pin acts as external interrupt |
| port_rd_i | input | 1 | Port read strobe, loads change reference |
| tmr_ovf_i | input | 1 | Timer overflow event pulse |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 3 | Status write data, 0 clears a flag |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 3 | Mask write data |
| eni_i | input | 1 | Enable-interrupt instruction |
| disi_i | input | 1 | Disable-interrupt instruction |
| irq_ack_i | input | 1 | Core takes the interrupt |
| sleep_enter_i | input | 1 | Sleep instruction executes |
| asleep_i | input | 1 | Core is in sleep |
| stat_o | output | 3 | Status flags {ext, change, timer} |
| mask_o | output | 3 | Mask register |
| irq_o | output | 1 | Interrupt request to the core |
| vector_o | output | ADDR_W | Interrupt vector address |
| wake_o | output | 1 | Wake request to the sleep controller |
| wake_vec_o | output | 1 | On wake: 1 = vector, 0 = next address |

## Verification
The bench builds the block with PORT_W = 6, SHARED_PIN = 2 and SYNC_STAGES = 3. With the shared pin in the middle of the port, it has input pins on both sides, so the exclusion of that one pin from change detection is tested against real neighbours. The three-stage synchroniser moves the change latency to four edges, so an off-by-one in the delay chain becomes visible. These settings also exercise the stage-count parameter at a value other than its default.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
   localparam int NSRC     = 3;
   localparam int SRC_TMR  = 0;
   localparam int SRC_PCHG = 1;
   localparam int SRC_EXT  = 2;
   typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("irq_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_change_det.sv
module irq_change_det #(
   parameter int W  = 8,
   parameter int SH = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] s_i,
   input  logic [W-1:0] dir_i,
   input  logic         ext_mode_i,
   input  logic         rd_i,
   output logic         chg_o,
   output logic         fall_o
);
   if (SH < 0 || SH >= W) begin : g_bad_shared
      $error("irq_change_det: SH must index a port pin");
   end

   logic [W-1:0] ref_q;
   logic         prev_q;
   logic [W-1:0] excl;
   logic [W-1:0] watch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         prev_q <= 1'b0;
      end else begin
         prev_q <= s_i[SH];
         if (rd_i) ref_q <= s_i;
      end
   end

   assign excl   = {{(W-1){1'b0}}, ext_mode_i} << SH;
   assign watch  = dir_i & ~excl;
   assign chg_o  = |((s_i ^ ref_q) & watch);
   assign fall_o = ext_mode_i & prev_q & ~s_i[SH];

   // R4
   ref_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> (ref_q == $past(s_i)));
endmodule

// File: rtl/irq_flags.sv
module irq_flags
   import irq_wake_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t evt_i,
   input  logic     st_wr_i,
   input  src_vec_t st_wdata_i,
   input  logic     mk_wr_i,
   input  src_vec_t mk_wdata_i,
   input  logic     eni_i,
   input  logic     disi_i,
   input  logic     ack_i,
   output src_vec_t stat_o,
   output src_vec_t mask_o,
   output logic     gie_o
);
   src_vec_t stat_q, mask_q, clr;
   logic     gie_q;

   assign clr = st_wr_i ? ~st_wdata_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
         gie_q  <= 1'b0;
      end else begin
         stat_q <= (stat_q & ~clr) | evt_i;
         if (mk_wr_i) mask_q <= mk_wdata_i;
         if (disi_i || ack_i)  gie_q <= 1'b0;
         else if (eni_i)       gie_q <= 1'b1;
      end
   end

   assign stat_o = stat_q;
   assign mask_o = mask_q;
   assign gie_o  = gie_q;

   // R2
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[SRC_TMR] |=> stat_q[SRC_TMR]);
   // R6
   stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_wr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
   // R8
   gie_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> !gie_q);
   // R8
   gie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eni_i && !disi_i && !ack_i) |=> gie_q);
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
   import irq_wake_pkg::*;
#(
   parameter int                  PORT_W      = 8,
   parameter int                  SHARED_PIN  = 0,
   parameter int                  SYNC_STAGES = 2,
   parameter int                  ADDR_W      = 12,
   parameter logic [ADDR_W-1:0]   VECTOR      = 'h008
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] port_i,
   input  logic [PORT_W-1:0] dir_i,
   input  logic              ext_mode_i,
   input  logic              port_rd_i,
   input  logic              tmr_ovf_i,
   input  logic              stat_wr_i,
   input  logic [NSRC-1:0]   stat_wdata_i,
   input  logic              mask_wr_i,
   input  logic [NSRC-1:0]   mask_wdata_i,
   input  logic              eni_i,
   input  logic              disi_i,
   input  logic              irq_ack_i,
   input  logic              sleep_enter_i,
   input  logic              asleep_i,
   output logic [NSRC-1:0]   stat_o,
   output logic [NSRC-1:0]   mask_o,
   output logic              irq_o,
   output logic [ADDR_W-1:0] vector_o,
   output logic              wake_o,
   output logic              wake_vec_o
);
   if (ADDR_W < 4) begin : g_bad_addr
      $error("irq_wake_ctrl: ADDR_W too small for the vector");
   end

   logic [PORT_W-1:0] port_s;
   logic              chg, fall, gie, slp_en_q;
   src_vec_t          evt;

   irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .d_i (port_i), .q_o (port_s)
   );

   irq_change_det #(.W(PORT_W), .SH(SHARED_PIN)) u_det (
      .clk (clk), .rst_n (rst_n), .s_i (port_s), .dir_i (dir_i),
      .ext_mode_i (ext_mode_i), .rd_i (port_rd_i),
      .chg_o (chg), .fall_o (fall)
   );

   always_comb begin
      evt           = '0;
      evt[SRC_TMR]  = tmr_ovf_i;
      evt[SRC_PCHG] = chg;
      evt[SRC_EXT]  = fall;
   end

   irq_flags u_flags (
      .clk (clk), .rst_n (rst_n), .evt_i (evt),
      .st_wr_i (stat_wr_i), .st_wdata_i (stat_wdata_i),
      .mk_wr_i (mask_wr_i), .mk_wdata_i (mask_wdata_i),
      .eni_i (eni_i), .disi_i (disi_i), .ack_i (irq_ack_i),
      .stat_o (stat_o), .mask_o (mask_o), .gie_o (gie)
   );

   // change-interrupt enable as it stood when sleep began
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             slp_en_q <= 1'b0;
      else if (sleep_enter_i) slp_en_q <= mask_o[SRC_PCHG];
   end

   assign irq_o      = gie & |(stat_o & mask_o);
   assign vector_o   = VECTOR;
   assign wake_o     = asleep_i & slp_en_q & stat_o[SRC_PCHG];
   assign wake_vec_o = gie;

   // R9
   wake_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_enter_i |=> (slp_en_q == $past(mask_o[SRC_PCHG])));
endmodule

// File: tb/test_irq_wake_ctrl.sv
module test_irq_wake_ctrl;
   localparam int PW = 6;
   localparam int SH = 2;
   localparam int SS = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PW-1:0] port_i = '0, dir_i = '0;
   logic ext_mode_i = 0, port_rd_i = 0, tmr_ovf_i = 0;
   logic stat_wr_i = 0, mask_wr_i = 0;
   logic [2:0] stat_wdata_i = '0, mask_wdata_i = '0;
   logic eni_i = 0, disi_i = 0, irq_ack_i = 0, sleep_enter_i = 0, asleep_i = 0;
   logic [2:0] stat_o, mask_o;
   logic irq_o, wake_o, wake_vec_o;
   logic [11:0] vector_o;

   int n_chk = 0, n_fail = 0;
   bit run_cmp = 0;

   always #2.5 clk = ~clk;

   irq_wake_ctrl #(.PORT_W(PW), .SHARED_PIN(SH), .SYNC_STAGES(SS)) i_irq_wake_ctrl (
      .clk (clk), .rst_n (rst_n), .port_i (port_i), .dir_i (dir_i),
      .ext_mode_i (ext_mode_i), .port_rd_i (port_rd_i), .tmr_ovf_i (tmr_ovf_i),
      .stat_wr_i (stat_wr_i), .stat_wdata_i (stat_wdata_i),
      .mask_wr_i (mask_wr_i), .mask_wdata_i (mask_wdata_i),
      .eni_i (eni_i), .disi_i (disi_i), .irq_ack_i (irq_ack_i),
      .sleep_enter_i (sleep_enter_i), .asleep_i (asleep_i),
      .stat_o (stat_o), .mask_o (mask_o), .irq_o (irq_o), .vector_o (vector_o),
      .wake_o (wake_o), .wake_vec_o (wake_vec_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   // behavioural reference model
   logic [PW-1:0] sq[$];
   logic [PW-1:0] m_ref;
   bit m_prev, m_gie, m_slp;
   logic [2:0] m_stat, m_mask;

   always @(posedge clk) begin
      if (!rst_n) begin
         sq.delete();
         for (int i = 0; i < SS; i++) sq.push_back('0);
         m_ref = '0; m_prev = 0; m_gie = 0; m_slp = 0;
         m_stat = '0; m_mask = '0;
      end else begin
         logic [PW-1:0] s, w, x;
         logic [2:0] ev, cl;
         s = sq[0];
         w = dir_i;
         if (ext_mode_i) w[SH] = 1'b0;
         x = (s ^ m_ref) & w;
         ev[0] = tmr_ovf_i;
         ev[1] = (x != 0);
         ev[2] = ext_mode_i && m_prev && !s[SH];
         cl = stat_wr_i ? ~stat_wdata_i : 3'b000;
         if (sleep_enter_i) m_slp = m_mask[1];
         m_stat = (m_stat & ~cl) | ev;
         if (mask_wr_i) m_mask = mask_wdata_i;
         if (disi_i || irq_ack_i) m_gie = 0;
         else if (eni_i) m_gie = 1;
         if (port_rd_i) m_ref = s;
         m_prev = s[SH];
         void'(sq.pop_front());
         sq.push_back(port_i);
      end
   end

   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         check("R6 model stat", stat_o, m_stat);
         check("R7 model mask", mask_o, m_mask);
         check("R7 model irq", irq_o, m_gie && ((m_stat & m_mask) != 0));
         check("R9 model wake", wake_o, asleep_i && m_slp && m_stat[1]);
         check("R10 model wake_vec", wake_vec_o, m_gie);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_stat(input logic [2:0] d);
      stat_wr_i = 1; stat_wdata_i = d; step(1); stat_wr_i = 0;
   endtask

   task automatic wr_mask(input logic [2:0] d);
      mask_wr_i = 1; mask_wdata_i = d; step(1); mask_wr_i = 0;
   endtask

   task automatic pulse_eni();  eni_i = 1;  step(1); eni_i = 0;  endtask
   task automatic pulse_disi(); disi_i = 1; step(1); disi_i = 0; endtask
   task automatic pulse_rd();   port_rd_i = 1; step(1); port_rd_i = 0; endtask

   initial begin
      #(5.0 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      step(4);
      rst_n = 1;
      run_cmp = 1;
      step(1);
      // R1 reset state
      check("R1 stat", stat_o, 0);
      check("R1 mask", mask_o, 0);
      check("R1 irq", irq_o, 0);
      check("R1 wake", wake_o, 0);
      check("R10 vector", vector_o, 12'h008);

      // R2 timer flag
      tmr_ovf_i = 1; step(1); tmr_ovf_i = 0;
      check("R2 timer flag", stat_o, 3'b001);

      // R7 mask and request, R8 global enable
      wr_mask(3'b001);
      check("R7 mask load", mask_o, 3'b001);
      check("R7 irq gated by gie", irq_o, 0);
      pulse_eni();
      check("R8 eni sets", irq_o, 1);
      irq_ack_i = 1; step(1); irq_ack_i = 0;
      check("R8 ack clears", irq_o, 0);
      pulse_eni();
      check("R8 eni again", irq_o, 1);
      eni_i = 1; disi_i = 1; step(1); eni_i = 0; disi_i = 0;
      check("R8 disi beats eni", irq_o, 0);

      // R6 clear semantics
      wr_stat(3'b110);
      check("R6 write 0 clears", stat_o, 3'b000);
      tmr_ovf_i = 1; stat_wr_i = 1; stat_wdata_i = 3'b000; step(1);
      tmr_ovf_i = 0; stat_wr_i = 0;
      check("R6 event beats clear", stat_o, 3'b001);
      wr_stat(3'b111);
      check("R6 write 1 no effect", stat_o, 3'b001);
      wr_stat(3'b000);

      // R3 change detection and latency
      dir_i = '1; ext_mode_i = 0;
      port_i = 6'b000001;
      step(SS);
      check("R3 not yet", stat_o, 3'b000);
      step(1);
      check("R3 change flag", stat_o, 3'b010);
      // R4 reference reload
      pulse_rd();
      wr_stat(3'b000);
      step(2);
      check("R4 no change after read", stat_o, 3'b000);
      // R3 output pin ignored
      dir_i = 6'b111110; port_i = 6'b000000;
      step(SS + 2);
      check("R3 output pin ignored", stat_o, 3'b000);
      // R5 shared pin in ext mode
      ext_mode_i = 1; port_i = 6'b000100;
      step(SS + 2);
      check("R5 rising ignored, R3 shared excluded", stat_o, 3'b000);
      port_i = 6'b000000;
      step(SS + 1);
      check("R5 falling edge flag", stat_o, 3'b100);
      wr_stat(3'b000);
      ext_mode_i = 0;

      // R9 wake armed at sleep entry
      pulse_rd();
      dir_i = '1;
      wr_stat(3'b000);
      wr_mask(3'b010);
      sleep_enter_i = 1; step(1); sleep_enter_i = 0;
      wr_mask(3'b000);
      asleep_i = 1;
      port_i = 6'b001000;
      step(SS + 1);
      check("R9 wake armed", wake_o, 1);
      check("R10 wake resumes", wake_vec_o, 0);
      pulse_eni();
      check("R10 wake vectors", wake_vec_o, 1);
      asleep_i = 0;
      step(SS);
      pulse_rd();
      wr_stat(3'b000);
      sleep_enter_i = 1; step(1); sleep_enter_i = 0;
      wr_mask(3'b010);
      asleep_i = 1;
      port_i = 6'b000000;
      step(SS + 1);
      check("R9 flag set", stat_o[1], 1);
      check("R9 not armed no wake", wake_o, 0);
      asleep_i = 0;

      // mixed stimulus against the model
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r;
         r = $urandom;
         port_i        = r[5:0];
         dir_i         = r[11:6];
         ext_mode_i    = r[12];
         port_rd_i     = r[13] & r[14];
         tmr_ovf_i     = r[15] & r[16];
         stat_wr_i     = r[17] & r[18];
         stat_wdata_i  = r[21:19];
         mask_wr_i     = r[22] & r[23];
         mask_wdata_i  = r[26:24];
         eni_i         = r[27];
         disi_i        = r[28] & r[29];
         irq_ack_i     = r[30] & r[27];
         sleep_enter_i = r[31] & r[12];
         asleep_i      = r[2];
         step(1);
      end
      finish_up();
   end
endmodule